// File: doc/BRIEF.md
# Immediate Size Lookup and Collector

This block sits in an instruction pre-decode path. When an opcode has been recognised, upstream logic pulses a start strobe with two codes: the effective operand size and the immediate type that the opcode calls for. The block turns that pair into a byte count through a fixed size table. Ten type codes are defined. Two of them are composite: one carries two immediates totalling three bytes, and the other is a far-pointer operand whose length depends on the operand size.

After start, the block takes immediate bytes from a byte-wide stream qualified by a valid bit. It places each byte little-endian into a 64-bit accumulator. When the counted byte arrives, it finalises the value and raises a one-cycle ready pulse. A 4-byte immediate is sign-extended to 64 bits on the way out; every other length is zero-extended. A 16-byte immediate keeps only its first eight bytes and raises an overflow flag. A pair that resolves to zero bytes completes at once, without waiting for any byte.

Top module: `imm_gather`

## Requirements
- R1: With operand-size code 0 (16-bit), type codes 0..9 give sizes 0,1,2,4,8,16,2,2,3,4 bytes, visible on `size_o` in the cycle after start.
- R2: With operand-size code 1 (32-bit), type codes 0..9 give sizes 0,1,2,4,8,16,4,4,3,6 bytes.
- R3: With operand-size code 2 or 3 (64-bit), type codes 0..9 give sizes 0,1,2,4,8,16,4,8,3,0 bytes, so the pointer type (code 9) needs no bytes.
- R4: Type codes 10 to 15 give a size of zero.
- R5: The k-th accepted byte (counting from 0) lands in bits 8k+7..8k of the immediate. Idle cycles between valid bytes do not disturb the assembly.
- R6: `ready_o` is high for exactly one cycle, in the cycle after the edge that accepted the last byte. Before that edge it stays low, and `busy_o` is low once `ready_o` rises.
- R7: A 4-byte result has bits 63..32 equal to bit 31. Results of any other length have every bit above their last byte at zero.
- R8: A 16-byte result holds the first eight bytes and sets `ovf_o`. Every other completion clears `ovf_o`.
- R9: A start whose size is zero raises `ready_o` in the next cycle with `imm_o` equal to 0 and `busy_o` low.
- R10: A start latches the size, clears the byte count and the accumulator, and overrides a collection in progress. The bytes taken before the restart do not appear in the result.
- R11: Bytes presented while idle, or in the same cycle as start, are ignored and produce no ready pulse.
- R12: After reset, `busy_o`, `ready_o` and `ovf_o` are 0, and `imm_o` and `size_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new immediate; samples the two codes |
| osz_i | input | 2 | Operand-size code: 0 = 16-bit, 1 = 32-bit, 2/3 = 64-bit |
| ityp_i | input | 4 | Immediate type code, 0..9 defined |
| byte_vld_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Next immediate byte |
| busy_o | output | 1 | Collection in progress |
| ready_o | output | 1 | One-cycle completion pulse |
| imm_o | output | 64 | Final immediate, held until the next completion |
| ovf_o | output | 1 | Last completion had more bytes than fit |
| size_o | output | 5 | Byte count latched at the last start |

## Verification
The bench builds the block with its default widths: 8-bit bytes, a 64-bit accumulator and a 5-bit size field. These widths are enough for the 16-byte type, so the overflow path and the discarded upper bytes can be reached. A vector table covers every operand-size and type pair, plus several undefined type codes. Each vector has its own byte pattern, so some dwords come out negative and some positive. Directed runs then cover restarts, idle and start-cycle bytes, and gaps in the valid stream.

// File: rtl/imm_gather_pkg.sv
package imm_gather_pkg;

  localparam int BYTE_W    = 8;
  localparam int IMM_W     = 64;
  localparam int IMM_BYTES = IMM_W / BYTE_W;
  localparam int MAX_BYTES = 16;
  localparam int SZ_W      = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(IMM_BYTES);

  typedef enum logic [3:0] {
    IT_NONE, IT_BYTE, IT_WORD, IT_DWORD, IT_QWORD,
    IT_OWORD, IT_VWORD, IT_ZWORD, IT_ENTER, IT_PTR
  } imm_type_e;

  typedef enum logic [1:0] {OSZ_16, OSZ_32, OSZ_64, OSZ_64B} osz_e;

  // Byte count of an immediate for a given operand size and type.
  function automatic logic [SZ_W-1:0] imm_len(input logic [1:0] osz, input logic [3:0] ityp);
    logic [SZ_W-1:0] n;
    case (ityp)
      IT_NONE:  n = SZ_W'(0);
      IT_BYTE:  n = SZ_W'(1);
      IT_WORD:  n = SZ_W'(2);
      IT_DWORD: n = SZ_W'(4);
      IT_QWORD: n = SZ_W'(8);
      IT_OWORD: n = SZ_W'(16);
      IT_VWORD: n = (osz == OSZ_16) ? SZ_W'(2) : SZ_W'(4);
      IT_ZWORD: n = (osz == OSZ_16) ? SZ_W'(2) : (osz == OSZ_32) ? SZ_W'(4) : SZ_W'(8);
      IT_ENTER: n = SZ_W'(3);
      IT_PTR:   n = (osz == OSZ_16) ? SZ_W'(4) : (osz == OSZ_32) ? SZ_W'(6) : SZ_W'(0);
      default:  n = SZ_W'(0);
    endcase
    return n;
  endfunction

  // Drop byte b into lane idx; lanes past the accumulator are discarded.
  function automatic logic [IMM_W-1:0] put_lane(input logic [IMM_W-1:0] acc,
                                                input logic [SZ_W-1:0]  idx,
                                                input logic [BYTE_W-1:0] b);
    logic [IMM_W-1:0] r;
    r = acc;
    if (idx < SZ_W'(IMM_BYTES))
      r[BYTE_W*idx[IDX_W-1:0] +: BYTE_W] = b;
    return r;
  endfunction

  // Final widening: four-byte values are sign-extended, others pass through.
  function automatic logic [IMM_W-1:0] widen(input logic [IMM_W-1:0] raw,
                                             input logic [SZ_W-1:0]  n);
    logic [IMM_W-1:0] r;
    r = raw;
    if (n == SZ_W'(4))
      r = {{(IMM_W-32){raw[31]}}, raw[31:0]};
    return r;
  endfunction

endpackage

// File: rtl/imm_size_lut.sv
module imm_size_lut
  import imm_gather_pkg::*;
(
  input  logic [1:0]      osz,
  input  logic [3:0]      ityp,
  output logic [SZ_W-1:0] len
);
  always_comb len = imm_len(osz, ityp);

  always_comb begin
    a_r3_ptr_wide_empty: assert (!(ityp == IT_PTR && osz[1]) || len == '0);
    a_r4_undef_empty:    assert (ityp < 4'd10 || len == '0);
  end
endmodule

// File: rtl/imm_byte_accum.sv
module imm_byte_accum
  import imm_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SZ_W-1:0]   len_in,
  input  logic              bvld,
  input  logic [BYTE_W-1:0] bdat,
  output logic              busy,
  output logic [SZ_W-1:0]   len_q,
  output logic              last_evt,
  output logic [IMM_W-1:0]  acc_fin
);
  logic [SZ_W-1:0]  cnt_q;
  logic [IMM_W-1:0] acc_q;
  logic             take;
  logic [SZ_W-1:0]  cnt_nx;

  assign take     = busy && bvld && !start;
  assign cnt_nx   = cnt_q + SZ_W'(1);
  assign last_evt = take && (cnt_nx == len_q);
  assign acc_fin  = put_lane(acc_q, cnt_q, bdat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      len_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (start) begin
      busy  <= (len_in != '0);
      len_q <= len_in;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      acc_q <= acc_fin;
      cnt_q <= cnt_nx;
      if (last_evt) busy <= 1'b0;
    end
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q < len_q);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0 && acc_q == '0);
endmodule

// File: rtl/imm_finish.sv
module imm_finish
  import imm_gather_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_evt,
  input  logic             last_evt,
  input  logic [IMM_W-1:0] acc_fin,
  input  logic [SZ_W-1:0]  len,
  output logic             ready,
  output logic [IMM_W-1:0] imm,
  output logic             ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      imm   <= '0;
      ovf   <= 1'b0;
    end else begin
      ready <= zero_evt || last_evt;
      if (zero_evt) begin
        imm <= '0;
        ovf <= 1'b0;
      end else if (last_evt) begin
        imm <= widen(acc_fin, len);
        ovf <= (len > SZ_W'(IMM_BYTES));
      end
    end
  end

  a_r8_overflow_tracks_len: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && !zero_evt |=> ovf == ($past(len) > SZ_W'(IMM_BYTES)));
endmodule

// File: rtl/imm_gather.sv
module imm_gather
  import imm_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        osz_i,
  input  logic [3:0]        ityp_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              ovf_o,
  output logic [SZ_W-1:0]   size_o
);
  logic [SZ_W-1:0]  lut_len;
  logic             zero_evt;
  logic             last_evt;
  logic [IMM_W-1:0] acc_fin;

  imm_size_lut u_lut (
    .osz  (osz_i),
    .ityp (ityp_i),
    .len  (lut_len)
  );

  assign zero_evt = start_i && (lut_len == '0);

  imm_byte_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .len_in   (lut_len),
    .bvld     (byte_vld_i),
    .bdat     (byte_i),
    .busy     (busy_o),
    .len_q    (size_o),
    .last_evt (last_evt),
    .acc_fin  (acc_fin)
  );

  imm_finish u_fin (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_evt (zero_evt),
    .last_evt (last_evt),
    .acc_fin  (acc_fin),
    .len      (size_o),
    .ready    (ready_o),
    .imm      (imm_o),
    .ovf      (ovf_o)
  );

  a_r9_zero_completes: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> ready_o && imm_o == '0 && !busy_o);
  a_r6_ready_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !busy_o);
  a_r7_dword_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && size_o == SZ_W'(4) |-> imm_o[IMM_W-1:32] == {(IMM_W-32){imm_o[31]}});
  a_r8_ovf_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> ovf_o == (size_o > SZ_W'(IMM_BYTES)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> !ready_o);
  a_r10_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && lut_len != '0 |=> busy_o && !ready_o);
endmodule

// File: tb/tb_imm_gather.sv
`timescale 1ns/1ps
module tb_imm_gather;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  osz_i = '0;
  logic [3:0]  ityp_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        busy_o, ready_o, ovf_o;
  logic [63:0] imm_o;
  logic [4:0]  size_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  imm_gather dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .osz_i(osz_i), .ityp_i(ityp_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .busy_o(busy_o), .ready_o(ready_o),
    .imm_o(imm_o), .ovf_o(ovf_o), .size_o(size_o)
  );

  // {osz, type, expected byte count}
  localparam logic [10:0] VEC [34] = '{
    {2'd0,4'd0,5'd0}, {2'd0,4'd1,5'd1}, {2'd0,4'd2,5'd2}, {2'd0,4'd3,5'd4}, {2'd0,4'd4,5'd8},
    {2'd0,4'd5,5'd16},{2'd0,4'd6,5'd2}, {2'd0,4'd7,5'd2}, {2'd0,4'd8,5'd3}, {2'd0,4'd9,5'd4},
    {2'd1,4'd0,5'd0}, {2'd1,4'd1,5'd1}, {2'd1,4'd2,5'd2}, {2'd1,4'd3,5'd4}, {2'd1,4'd4,5'd8},
    {2'd1,4'd5,5'd16},{2'd1,4'd6,5'd4}, {2'd1,4'd7,5'd4}, {2'd1,4'd8,5'd3}, {2'd1,4'd9,5'd6},
    {2'd2,4'd0,5'd0}, {2'd2,4'd1,5'd1}, {2'd2,4'd2,5'd2}, {2'd2,4'd3,5'd4}, {2'd2,4'd4,5'd8},
    {2'd2,4'd5,5'd16},{2'd2,4'd6,5'd4}, {2'd2,4'd7,5'd8}, {2'd2,4'd8,5'd3}, {2'd2,4'd9,5'd0},
    {2'd3,4'd7,5'd8}, {2'd3,4'd9,5'd0}, {2'd1,4'd12,5'd0},{2'd0,4'd15,5'd0}
  };

  function automatic logic [7:0] bval(input int seed, input int k);
    return 8'(seed * 7 + k * 59 + 8'h9C);
  endfunction

  function automatic logic [63:0] expect_imm(input int n, input int seed);
    logic [63:0] v = '0;
    for (int k = 0; k < n && k < 8; k++) v[8*k +: 8] = bval(seed, k);
    if (n == 4 && v[31]) v[63:32] = '1;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] o, input logic [3:0] t, input bit with_byte);
    @(negedge clk);
    start_i = 1'b1; osz_i = o; ityp_i = t;
    byte_vld_i = with_byte; byte_i = 8'hA5;
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  // Positioned at a negedge; feeds n bytes, optionally with idle gaps.
  task automatic feed(input int n, input int seed, input bit gap);
    for (int k = 0; k < n; k++) begin
      byte_vld_i = 1'b1; byte_i = bval(seed, k);
      @(negedge clk);
      byte_vld_i = 1'b0;
      if (k == n - 2) chk("R6", "ready early", 64'(ready_o), 64'd0);
      if (gap && k < n - 1) @(negedge clk);
    end
  endtask

  task automatic finish_checks(input int n, input int seed, input string req);
    chk("R6", "ready on last", 64'(ready_o), 64'd1);
    chk("R6", "busy after done", 64'(busy_o), 64'd0);
    chk(req, "immediate", imm_o, expect_imm(n, seed));
    chk("R8", "overflow", 64'(ovf_o), 64'(n > 8));
    @(negedge clk);
    chk("R6", "ready one cycle", 64'(ready_o), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "busy", 64'(busy_o), 64'd0);
    chk("R12", "ready", 64'(ready_o), 64'd0);
    chk("R12", "imm", imm_o, 64'd0);
    chk("R12", "ovf", 64'(ovf_o), 64'd0);
    chk("R12", "size", 64'(size_o), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 34; i++) begin
      int n;
      string req;
      n = int'(VEC[i][4:0]);
      req = (VEC[i][8:5] > 4'd9) ? "R4" : (VEC[i][10:9] == 2'd0) ? "R1" :
            (VEC[i][10:9] == 2'd1) ? "R2" : "R3";
      do_start(VEC[i][10:9], VEC[i][8:5], 1'b0);
      chk(req, "size", 64'(size_o), 64'(n));
      if (n == 0) begin
        chk("R9", "zero ready", 64'(ready_o), 64'd1);
        chk("R9", "zero imm", imm_o, 64'd0);
        chk("R9", "zero busy", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk("R9", "zero pulse", 64'(ready_o), 64'd0);
      end else begin
        feed(n, i, 1'b0);
        finish_checks(n, i, (n == 4) ? "R7" : "R5");
      end
    end

    // R7: positive dword keeps upper half zero
    do_start(2'd2, 4'd3, 1'b0);
    begin
      int s;
      s = 0;
      for (int t = 0; t < 64; t++) if (!bval(t, 3)[7]) begin s = t; break; end
      feed(4, s, 1'b0);
      finish_checks(4, s, "R7");
    end

    // R5: gaps in the valid stream
    do_start(2'd2, 4'd4, 1'b0);
    feed(8, 41, 1'b1);
    finish_checks(8, 41, "R5");

    // R11: bytes while idle are ignored
    begin
      logic [63:0] held;
      held = imm_o;
      for (int k = 0; k < 4; k++) begin
        byte_vld_i = 1'b1; byte_i = 8'h5A;
        @(negedge clk);
        chk("R11", "idle ready", 64'(ready_o), 64'd0);
      end
      byte_vld_i = 1'b0;
      chk("R11", "idle imm held", imm_o, held);
      chk("R11", "idle busy", 64'(busy_o), 64'd0);
    end

    // R11: byte in the start cycle is ignored
    do_start(2'd1, 4'd3, 1'b1);
    feed(4, 17, 1'b0);
    finish_checks(4, 17, "R11");

    // R10: restart discards earlier bytes
    do_start(2'd2, 4'd4, 1'b0);
    feed(3, 99, 1'b0);
    chk("R10", "busy mid", 64'(busy_o), 64'd1);
    do_start(2'd0, 4'd2, 1'b0);
    chk("R10", "size relatched", 64'(size_o), 64'd2);
    feed(2, 23, 1'b0);
    finish_checks(2, 23, "R10");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule